// File: doc/BRIEF.md
# Status Word and Exception Return Unit

This block keeps a processor's status word and its exception-pending word, and carries out four single-cycle commands on them: switching interrupts off, switching them on, returning from an exception handler, and raising one of four software interrupts. The core pulses one command strobe at a time, or several at once, and supplies the two saved return addresses: one for ordinary exceptions and one for non-maskable ones.

On a return, the unit reads the non-maskable-in-progress flag in the status word. If the flag is set, the unit takes the non-maskable return address and clears the flag. If the flag is clear, it takes the ordinary return address and copies the saved user-mode and interrupt-enable flags back into their live positions. In both cases the target has bit 0 forced low. The target appears on a registered output together with a one-cycle valid pulse, and the core's fetch stage consumes it from there.

Software can also load either word as a whole through a control-register write port. That port has the lowest priority of all actions.

Top module: `psw_exc_unit`

## Requirements
- R1: While reset is asserted and after it is released, the status word, the exception word and the return target are all zero, and the return-valid output is low.
- R2: A disable command clears status bit 0 on the next clock edge. Every other status bit and the exception word stay unchanged.
- R3: An enable command sets status bit 0 on the next clock edge, whatever its earlier value. Every other status bit and the exception word stay unchanged.
- R4: A return command issued while status bit 9 is 1 does three things one cycle later: the return target equals the non-maskable saved address with bit 0 forced to 0, return-valid is high, and status bit 9 is 0. All other status bits stay unchanged.
- R5: A return command issued while status bit 9 is 0 does the following one cycle later. The return target equals the ordinary saved address with bit 0 forced to 0, and return-valid is high. Status bit 2 takes the old value of bit 3, and bit 0 takes the old value of bit 1. Bits 1, 3 and 9 and all other bits keep their values.
- R6: A software-interrupt command with a 2-bit index n sets bit 4+n of the exception word, so n=0..3 maps to bits 4..7. Bits that were already set stay set, and no other bit changes.
- R7: When several actions are requested in one cycle, only one is carried out, in this priority order: return, then disable, then enable, then software interrupt, then register write. The lower-priority requests in that cycle have no effect.
- R8: A register write with select 0 loads the whole status word from the write data. With select 1 it loads the whole exception word. The new value is visible on the next clock edge.
- R9: In any cycle after one without a return command, return-valid is low and the return target keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdDisable | input | 1 | Disable-interrupt command strobe |
| cmdEnable | input | 1 | Enable-interrupt command strobe |
| cmdReturn | input | 1 | Return-from-exception command strobe |
| cmdSoftIrq | input | 1 | Software-interrupt command strobe |
| softIrqIdx | input | 2 | Index of the software interrupt to raise |
| savedEpc | input | 32 | Saved return address for ordinary exceptions |
| savedNpc | input | 32 | Saved return address for non-maskable exceptions |
| crWrEn | input | 1 | Control-register write strobe |
| crWrSel | input | 1 | Write target: 0 status word, 1 exception word |
| crWrData | input | 32 | Control-register write data |
| statusReg | output | 32 | Current status word |
| excReg | output | 32 | Current exception-pending word |
| retPc | output | 32 | Registered return target, bit 0 always 0 |
| retValid | output | 1 | One-cycle pulse marking a new return target |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses and words, and a 2-bit software-interrupt index based at bit 4. These values put all four pending bits and the non-maskable flag at bit 9 within reach. Random register writes load status words with bit 9 both set and clear, so returns go down both paths and the flag-copy rule is exercised with every combination of bits 1 and 3. The random stimulus also draws collisions of several strobes in one cycle, and each priority pairing turns up many times.

// File: rtl/psw_exc_pkg.sv
package psw_exc_pkg;

  // Status-word flag positions; the return sequence depends on these.
  localparam int IntEnCurBit  = 0;
  localparam int IntEnPrvBit  = 1;
  localparam int UserCurBit   = 2;
  localparam int UserPrvBit   = 3;
  localparam int NmiActiveBit = 9;

  // One action per cycle, chosen by the control module.
  typedef struct packed {
    logic doRet;
    logic doDis;
    logic doEn;
    logic doSwi;
    logic doWrSt;
    logic doWrExc;
  } ctl_strobes_t;

endpackage

// File: rtl/psw_exc_ctrl.sv
module psw_exc_ctrl
  import psw_exc_pkg::*;
(
  input  logic         cmdDisable,
  input  logic         cmdEnable,
  input  logic         cmdReturn,
  input  logic         cmdSoftIrq,
  input  logic         crWrEn,
  input  logic         crWrSel,
  output ctl_strobes_t ctl
);

  // Fixed priority: return, disable, enable, software interrupt, write.
  always_comb begin
    ctl = '0;
    if (cmdReturn) begin
      ctl.doRet = 1'b1;
    end else if (cmdDisable) begin
      ctl.doDis = 1'b1;
    end else if (cmdEnable) begin
      ctl.doEn = 1'b1;
    end else if (cmdSoftIrq) begin
      ctl.doSwi = 1'b1;
    end else if (crWrEn) begin
      if (crWrSel) begin
        ctl.doWrExc = 1'b1;
      end else begin
        ctl.doWrSt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/psw_exc_path.sv
module psw_exc_path
  import psw_exc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int STAT_W    = 32,
  parameter int EXC_W     = 32,
  parameter int SWI_IDX_W = 2,
  parameter int SWI_BASE  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobes_t         ctl,
  input  logic [SWI_IDX_W-1:0] softIrqIdx,
  input  logic [PC_W-1:0]      savedEpc,
  input  logic [PC_W-1:0]      savedNpc,
  input  logic [31:0]          crWrData,
  output logic [STAT_W-1:0]    statusReg,
  output logic [EXC_W-1:0]     excReg,
  output logic [PC_W-1:0]      retPc,
  output logic                 retValid
);

  localparam int SWI_CNT = 1 << SWI_IDX_W;
  localparam logic [PC_W-1:0] EVEN_MASK = ~{{(PC_W-1){1'b0}}, 1'b1};

  logic [STAT_W-1:0] statusNext;
  logic [EXC_W-1:0]  excNext;
  logic [EXC_W-1:0]  swiMask;
  logic [PC_W-1:0]   retPcNext;
  logic              nmiActive;

  assign nmiActive = statusReg[NmiActiveBit];

  // One-hot pending mask for the selected software interrupt.
  generate
    for (genvar g = 0; g < EXC_W; g++) begin : g_swiMask
      if (g >= SWI_BASE && g < SWI_BASE + SWI_CNT) begin : g_live
        assign swiMask[g] = (softIrqIdx == SWI_IDX_W'(g - SWI_BASE));
      end else begin : g_dead
        assign swiMask[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    statusNext = statusReg;
    if (ctl.doRet) begin
      if (nmiActive) begin
        statusNext[NmiActiveBit] = 1'b0;
      end else begin
        statusNext[UserCurBit]  = statusReg[UserPrvBit];
        statusNext[IntEnCurBit] = statusReg[IntEnPrvBit];
      end
    end else if (ctl.doDis) begin
      statusNext[IntEnCurBit] = 1'b0;
    end else if (ctl.doEn) begin
      statusNext[IntEnCurBit] = 1'b1;
    end else if (ctl.doWrSt) begin
      statusNext = crWrData[STAT_W-1:0];
    end
  end

  always_comb begin
    excNext = excReg;
    if (ctl.doSwi) begin
      excNext = excReg | swiMask;
    end else if (ctl.doWrExc) begin
      excNext = crWrData[EXC_W-1:0];
    end
  end

  assign retPcNext = (nmiActive ? savedNpc : savedEpc) & EVEN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      excReg    <= '0;
      retPc     <= '0;
      retValid  <= 1'b0;
    end else begin
      statusReg <= statusNext;
      excReg    <= excNext;
      retValid  <= ctl.doRet;
      if (ctl.doRet) begin
        retPc <= retPcNext;
      end
    end
  end

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doDis |=> !statusReg[IntEnCurBit]); // R2
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doEn |=> statusReg[IntEnCurBit]); // R3
  AST_NMI_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doRet && statusReg[NmiActiveBit]) |=>
      (!statusReg[NmiActiveBit] && retPc == ($past(savedNpc) & EVEN_MASK))); // R4
  AST_RET_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> !retPc[0]); // R4
  AST_NORMAL_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doRet && !statusReg[NmiActiveBit]) |=>
      (statusReg[UserCurBit] == $past(statusReg[UserPrvBit]) &&
       statusReg[IntEnCurBit] == $past(statusReg[IntEnPrvBit]))); // R5
  AST_PREV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doRet |=> ($stable(statusReg[IntEnPrvBit]) && $stable(statusReg[UserPrvBit]))); // R5
  AST_SWI_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doSwi |=> excReg[SWI_BASE + int'($past(softIrqIdx))]); // R6
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.doRet |=> (!retValid && $stable(retPc))); // R9

endmodule

// File: rtl/psw_exc_unit.sv
module psw_exc_unit
  import psw_exc_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int STAT_W    = 32,
  parameter int EXC_W     = 32,
  parameter int SWI_IDX_W = 2,
  parameter int SWI_BASE  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdDisable,
  input  logic                 cmdEnable,
  input  logic                 cmdReturn,
  input  logic                 cmdSoftIrq,
  input  logic [SWI_IDX_W-1:0] softIrqIdx,
  input  logic [PC_W-1:0]      savedEpc,
  input  logic [PC_W-1:0]      savedNpc,
  input  logic                 crWrEn,
  input  logic                 crWrSel,
  input  logic [31:0]          crWrData,
  output logic [STAT_W-1:0]    statusReg,
  output logic [EXC_W-1:0]     excReg,
  output logic [PC_W-1:0]      retPc,
  output logic                 retValid
);

  ctl_strobes_t ctl;

  psw_exc_ctrl u_ctrl (
    .cmdDisable (cmdDisable),
    .cmdEnable  (cmdEnable),
    .cmdReturn  (cmdReturn),
    .cmdSoftIrq (cmdSoftIrq),
    .crWrEn     (crWrEn),
    .crWrSel    (crWrSel),
    .ctl        (ctl)
  );

  psw_exc_path #(
    .PC_W      (PC_W),
    .STAT_W    (STAT_W),
    .EXC_W     (EXC_W),
    .SWI_IDX_W (SWI_IDX_W),
    .SWI_BASE  (SWI_BASE)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .softIrqIdx (softIrqIdx),
    .savedEpc   (savedEpc),
    .savedNpc   (savedNpc),
    .crWrData   (crWrData),
    .statusReg  (statusReg),
    .excReg     (excReg),
    .retPc      (retPc),
    .retValid   (retValid)
  );

  // Port-level priority checks spanning both submodules.
  AST_RET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    cmdReturn |=> retValid); // R7
  AST_DIS_BEATS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDisable && cmdEnable && !cmdReturn) |=> !statusReg[IntEnCurBit]); // R7
  AST_WRITE_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    (crWrEn && cmdSoftIrq && !cmdReturn && !cmdDisable && !cmdEnable) |=>
      $stable(statusReg)); // R7

endmodule

// File: tb/psw_exc_unit_tb.sv
module psw_exc_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdDisable = 0, cmdEnable = 0, cmdReturn = 0, cmdSoftIrq = 0;
  logic [1:0]  softIrqIdx = 0;
  logic [31:0] savedEpc = 0, savedNpc = 0;
  logic        crWrEn = 0, crWrSel = 0;
  logic [31:0] crWrData = 0;
  logic [31:0] statusReg, excReg, retPc;
  logic        retValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] mStat, mExc, mPc;
  logic        mValid;
  string       mTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_exc_unit u_dut (
    .clk(clk), .rstN(rstN),
    .cmdDisable(cmdDisable), .cmdEnable(cmdEnable),
    .cmdReturn(cmdReturn), .cmdSoftIrq(cmdSoftIrq),
    .softIrqIdx(softIrqIdx), .savedEpc(savedEpc), .savedNpc(savedNpc),
    .crWrEn(crWrEn), .crWrSel(crWrSel), .crWrData(crWrData),
    .statusReg(statusReg), .excReg(excReg), .retPc(retPc), .retValid(retValid)
  );

  // Behavioural reference, evaluated at each rising edge.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat = 0; mExc = 0; mPc = 0; mValid = 0; mTag = "R1";
    end else begin
      int nReq;
      nReq = int'(cmdReturn) + int'(cmdDisable) + int'(cmdEnable) +
             int'(cmdSoftIrq) + int'(crWrEn);
      mValid = 0;
      mTag = "R9";
      if (cmdReturn) begin
        mValid = 1;
        if (mStat[9]) begin
          mPc = savedNpc & 32'hFFFF_FFFE;
          mStat[9] = 1'b0;
          mTag = "R4";
        end else begin
          mPc = savedEpc & 32'hFFFF_FFFE;
          mStat[2] = mStat[3];
          mStat[0] = mStat[1];
          mTag = "R5";
        end
      end else if (cmdDisable) begin
        mStat[0] = 1'b0; mTag = "R2";
      end else if (cmdEnable) begin
        mStat[0] = 1'b1; mTag = "R3";
      end else if (cmdSoftIrq) begin
        mExc[4 + int'(softIrqIdx)] = 1'b1; mTag = "R6";
      end else if (crWrEn) begin
        if (crWrSel) mExc = crWrData; else mStat = crWrData;
        mTag = "R8";
      end
      if (nReq > 1) mTag = "R7";
    end
  end

  task automatic compare();
    compared++;
    if (statusReg !== mStat || excReg !== mExc || retPc !== mPc || retValid !== mValid) begin
      mismatched++;
      $display("FAIL %s: got st=%h exc=%h pc=%h v=%b expected st=%h exc=%h pc=%h v=%b",
               mTag, statusReg, excReg, retPc, retValid, mStat, mExc, mPc, mValid);
    end
  endtask

  task automatic drive(input logic r, input logic d, input logic e, input logic s,
                       input logic [1:0] idx, input logic w, input logic sel,
                       input logic [31:0] data);
    cmdReturn = r; cmdDisable = d; cmdEnable = e; cmdSoftIrq = s;
    softIrqIdx = idx; crWrEn = w; crWrSel = sel; crWrData = data;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 2'd0, 0, 0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    savedEpc = 32'h0000_1235;
    savedNpc = 32'h0000_ABC7;
    repeat (2) @(negedge clk);
    compare();                                   // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    compare();                                   // R1 after release
    drive(0, 0, 0, 0, 0, 1, 0, 32'h0000_020A);   // R8 status write, NMI set
    drive(0, 0, 0, 0, 0, 1, 1, 32'h0000_0001);   // R8 exception write
    drive(1, 0, 0, 0, 0, 0, 0, 0);               // R4 non-maskable return
    idle();                                      // R9 valid drops, pc holds
    drive(1, 0, 0, 0, 0, 0, 0, 0);               // R5 ordinary return
    drive(0, 0, 1, 0, 0, 0, 0, 0);               // R3
    drive(0, 0, 1, 0, 0, 0, 0, 0);               // R3 already set
    drive(0, 1, 0, 0, 0, 0, 0, 0);               // R2
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 2'(i), 0, 0, 0); // R6
    drive(0, 0, 0, 1, 2'd2, 0, 0, 0);            // R6 already pending
    drive(1, 1, 1, 1, 2'd0, 1, 0, 32'hFFFF_FFFF); // R7 return wins
    drive(0, 1, 1, 0, 0, 0, 0, 0);               // R7 disable over enable
    drive(0, 0, 1, 1, 2'd1, 0, 0, 0);            // R7 enable over soft irq
    drive(0, 0, 0, 1, 2'd3, 1, 1, 32'h0);        // R7 soft irq over write
    idle();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] wd;
      wd = $urandom;
      savedEpc = $urandom;
      savedNpc = $urandom;
      drive(($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
            ($urandom % 4) == 0, 2'($urandom), ($urandom % 3) == 0,
            1'($urandom), wd);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule